// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two USB data lines and reports a bus reset once a single-ended-zero condition (both lines low) has lasted long enough. The lines are brought into the clock domain through a short synchronizer. A free-running tick with an 8 µs period times the condition. An SE0 is accepted only when it is still present on two ticks in a row. With that rule a reset is always seen once the SE0 passes 16 µs, and never for one shorter than 8 µs. Any sample that is not SE0 before the threshold restarts the count.

A detection sets a sticky status flag. Firmware clears the flag by writing 0 to it. If the device is in suspend when the reset is detected, the block sends one-cycle requests to leave suspend and to restart the clock oscillator. On every detection it also raises a hold that keeps the processor in reset until the lines leave SE0.

Top module: `usb_bus_reset_det`

## Requirements
- R1: A line sample counts as SE0 only when both `line_dp` and `line_dm` read 0 after the synchronizer. The states J ({dp,dm}=10), K (01) and SE1 (11) never produce a detection.
- R2: A detection happens at the clock edge that samples `tick_8us` high while SE0 is present, when the previous tick was also seen in the same unbroken SE0. A single tick in SE0 never produces a detection.
- R3: Any synchronized non-SE0 sample before the threshold clears the tick count. After a glitch, two new ticks are needed.
- R4: One unbroken SE0 produces exactly one detection, however many ticks it lasts.
- R5: `reset_flag` goes to 1 at the detection edge and stays at 1. It is cleared only by a cycle with `flag_wr`=1 and `flag_wr_data`=0. A write with data 1 leaves it unchanged.
- R6: When a detection and a clearing write fall on the same edge, the detection wins and `reset_flag` reads 1.
- R7: When `suspended` is high at the detection edge, `suspend_clear` and `osc_restart` are both high for exactly the one cycle after that edge. When `suspended` is low, neither rises.
- R8: `cpu_hold` rises at the detection edge. It stays high while SE0 persists and falls on the third clock edge after the lines leave SE0 (two synchronizer edges plus one register).
- R9: While `rst_n` is low and after it is released, `reset_flag`, `cpu_hold`, `suspend_clear` and `osc_restart` are 0, and the tick count is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dp | input | 1 | D+ line level, asynchronous |
| line_dm | input | 1 | D- line level, asynchronous |
| tick_8us | input | 1 | One-cycle pulse every 8 µs |
| suspended | input | 1 | Device is currently in suspend |
| flag_wr | input | 1 | Firmware write strobe for the status flag |
| flag_wr_data | input | 1 | Value written; 0 clears the flag |
| reset_flag | output | 1 | Sticky bus-reset status flag |
| suspend_clear | output | 1 | One-cycle request to leave suspend |
| osc_restart | output | 1 | One-cycle request to restart the oscillator |
| cpu_hold | output | 1 | Holds the processor in reset |

## Verification
The two functions that can fall in one cycle are the detection that sets the status flag and the firmware write that clears it. The bench provokes this by lining up the second qualifying tick with a write of 0 on the same clock edge, while the flag is still 0. It then expects the flag to read 1. The bench separately checks that a write alone clears the flag and that a detection alone sets it, so each mutation of the priority rule shows up in at least one check.

// File: rtl/bre_pkg.sv
package bre_pkg;

    // Line state encoded as {dp, dm}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_TICKS_REQ   = 2;

endpackage

// File: rtl/bre_line_sync.sv
module bre_line_sync
    import bre_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dp_i,
    input  logic        dm_i,
    output line_state_e state_o,
    output logic        se0_o
);

    typedef struct packed {
        logic [STAGES-1:0] dp;
        logic [STAGES-1:0] dm;
    } sync_t;

    sync_t sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                sync_d    = sync_q;
                sync_d.dp = dp_i;
                sync_d.dm = dm_i;
            end
        end else begin : g_chain
            always_comb begin
                sync_d    = sync_q;
                sync_d.dp = {sync_q.dp[STAGES-2:0], dp_i};
                sync_d.dm = {sync_q.dm[STAGES-2:0], dm_i};
            end
        end
    endgenerate

    // Idle bus (J) on reset so no SE0 is seen before the lines are sampled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q.dp <= '1;
            sync_q.dm <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign state_o = line_state_e'({sync_q.dp[STAGES-1], sync_q.dm[STAGES-1]});
    assign se0_o   = (state_o == LS_SE0);

endmodule

// File: rtl/bre_se0_qual.sv
module bre_se0_qual
    import bre_pkg::*;
#(
    parameter int unsigned TICKS_REQ = DEF_TICKS_REQ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0_i,
    input  logic tick_i,
    output logic det_o
);

    localparam int unsigned CW = $clog2(TICKS_REQ + 1);
    localparam logic [CW-1:0] FULL = CW'(TICKS_REQ);
    localparam logic [CW-1:0] LAST = CW'(TICKS_REQ - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;
    logic  det;

    always_comb begin
        qual_d = qual_q;
        det    = 1'b0;
        if (!se0_i) begin
            qual_d.cnt = '0;
        end else if (tick_i && qual_q.cnt != FULL) begin
            qual_d.cnt = qual_q.cnt + CW'(1);
            det        = (qual_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end

    assign det_o = det;

    // R2
    det_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> (se0_i && tick_i));

    // R3
    glitch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !se0_i |=> !det);

    // R4
    single_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> !det);

endmodule

// File: rtl/bre_status_flag.sv
module bre_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic wr_i,
    input  logic wr_data_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (det_i)                  flag_d.flag = 1'b1;
        else if (wr_i && !wr_data_i) flag_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q.flag;

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q.flag && !(wr_i && !wr_data_i)) |=> flag_q.flag);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> flag_q.flag);

endmodule

// File: rtl/bre_wake_seq.sv
module bre_wake_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic suspended_i,
    input  logic se0_i,
    output logic wake_o,
    output logic hold_o
);

    typedef struct packed {
        logic wake;
        logic hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.wake = det_i && suspended_i;
        seq_d.hold = det_i || (seq_q.hold && se0_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign wake_o = seq_q.wake;
    assign hold_o = seq_q.hold;

    // R7
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.wake |=> !seq_q.wake);

    // R7
    wake_only_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_i && !suspended_i) |=> !seq_q.wake);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!se0_i && !det_i) |=> !seq_q.hold);

endmodule

// File: rtl/usb_bus_reset_det.sv
module usb_bus_reset_det
    import bre_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned TICKS_REQ   = DEF_TICKS_REQ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_dp,
    input  logic line_dm,
    input  logic tick_8us,
    input  logic suspended,
    input  logic flag_wr,
    input  logic flag_wr_data,
    output logic reset_flag,
    output logic suspend_clear,
    output logic osc_restart,
    output logic cpu_hold
);

    line_state_e line_state;
    logic        se0;
    logic        det;
    logic        wake;

    bre_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_i    (line_dp),
        .dm_i    (line_dm),
        .state_o (line_state),
        .se0_o   (se0)
    );

    bre_se0_qual #(.TICKS_REQ(TICKS_REQ)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .se0_i  (se0),
        .tick_i (tick_8us),
        .det_o  (det)
    );

    bre_status_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_i     (det),
        .wr_i      (flag_wr),
        .wr_data_i (flag_wr_data),
        .flag_o    (reset_flag)
    );

    bre_wake_seq u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_i       (det),
        .suspended_i (suspended),
        .se0_i       (se0),
        .wake_o      (wake),
        .hold_o      (cpu_hold)
    );

    assign suspend_clear = wake;
    assign osc_restart   = wake;

    // R1
    se0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> (line_state == LS_SE0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!reset_flag && !cpu_hold && !suspend_clear));

endmodule

// File: tb/usb_bus_reset_det_test.sv
module usb_bus_reset_det_test;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_dp = 1'b1, line_dm = 1'b0;
    logic tick_8us = 1'b0, suspended = 1'b0;
    logic flag_wr = 1'b0, flag_wr_data = 1'b0;
    logic reset_flag, suspend_clear, osc_restart, cpu_hold;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bus_reset_det uut (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
        .tick_8us(tick_8us), .suspended(suspended), .flag_wr(flag_wr),
        .flag_wr_data(flag_wr_data), .reset_flag(reset_flag),
        .suspend_clear(suspend_clear), .osc_restart(osc_restart),
        .cpu_hold(cpu_hold)
    );

    // Vector: {dp,dm}[11:10], ticks_a[9:6], glitch[5], ticks_b[4:1], expect[0]
    localparam int NVEC = 9;
    localparam logic [11:0] VEC [NVEC] = '{
        {2'b00, 4'd0, 1'b0, 4'd0, 1'b0},
        {2'b00, 4'd1, 1'b0, 4'd0, 1'b0},
        {2'b00, 4'd2, 1'b0, 4'd0, 1'b1},
        {2'b00, 4'd5, 1'b0, 4'd0, 1'b1},
        {2'b00, 4'd1, 1'b1, 4'd1, 1'b0},
        {2'b00, 4'd1, 1'b1, 4'd2, 1'b1},
        {2'b10, 4'd3, 1'b0, 4'd0, 1'b0},
        {2'b01, 4'd3, 1'b0, 4'd0, 1'b0},
        {2'b11, 4'd3, 1'b0, 4'd0, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick_8us = 1'b1;
        step(1);
        tick_8us = 1'b0;
    endtask

    task automatic set_lines(input logic [1:0] s);
        {line_dp, line_dm} = s;
    endtask

    task automatic clear_flag();
        flag_wr = 1'b1; flag_wr_data = 1'b0;
        step(1);
        flag_wr = 1'b0;
    endtask

    task automatic go_idle();
        set_lines(2'b10);
        step(4);
        clear_flag();
        step(1);
    endtask

    initial begin
        step(3);
        chk("R9 flag in reset", reset_flag, 1'b0);
        chk("R9 hold in reset", cpu_hold, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R9 flag after reset", reset_flag, 1'b0);
        chk("R9 wake after reset", suspend_clear, 1'b0);

        // Table walk: R1 R2 R3
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            set_lines(v[11:10]);
            step(3);
            for (int t = 0; t < int'(v[9:6]); t++) begin pulse_tick(); step(1); end
            if (v[5]) begin
                set_lines(2'b10); step(3);
                set_lines(v[11:10]); step(3);
            end
            for (int t = 0; t < int'(v[4:1]); t++) begin pulse_tick(); step(1); end
            chk($sformatf("R2/R3/R1 vector %0d flag", i), reset_flag, v[0]);
            chk($sformatf("R8 vector %0d hold during SE0", i), cpu_hold, v[0]);
            go_idle();
            chk($sformatf("R5 vector %0d flag cleared", i), reset_flag, 1'b0);
        end

        // R2 exact edge, R7 suspended, R8 release timing
        suspended = 1'b1;
        set_lines(2'b00); step(3);
        pulse_tick(); step(1);
        chk("R2 one tick no flag", reset_flag, 1'b0);
        pulse_tick();
        chk("R2 flag at second tick", reset_flag, 1'b1);
        chk("R7 suspend_clear pulse", suspend_clear, 1'b1);
        chk("R7 osc_restart pulse", osc_restart, 1'b1);
        chk("R8 hold rises", cpu_hold, 1'b1);
        step(1);
        chk("R7 suspend_clear one cycle", suspend_clear, 1'b0);
        chk("R7 osc_restart one cycle", osc_restart, 1'b0);
        // R4: more ticks in same SE0, flag cleared, no new detection
        clear_flag();
        for (int t = 0; t < 4; t++) begin
            pulse_tick();
            chk("R4 no second wake", suspend_clear, 1'b0);
            step(1);
        end
        chk("R4 no second detection", reset_flag, 1'b0);
        chk("R8 hold while SE0", cpu_hold, 1'b1);
        set_lines(2'b10);
        step(2);
        chk("R8 hold two edges after release", cpu_hold, 1'b1);
        step(1);
        chk("R8 hold drops third edge", cpu_hold, 1'b0);
        suspended = 1'b0;
        step(2);

        // R7 not suspended
        set_lines(2'b00); step(3);
        pulse_tick(); step(1);
        pulse_tick();
        chk("R7 no wake when awake", suspend_clear, 1'b0);
        chk("R7 no osc when awake", osc_restart, 1'b0);
        chk("R8 hold when awake", cpu_hold, 1'b1);
        // R5 write of 1 does not clear
        flag_wr = 1'b1; flag_wr_data = 1'b1;
        step(1);
        flag_wr = 1'b0;
        chk("R5 write 1 keeps flag", reset_flag, 1'b1);
        clear_flag();
        chk("R5 write 0 clears flag", reset_flag, 1'b0);
        go_idle();

        // R6 detection and clear on same edge
        set_lines(2'b00); step(3);
        pulse_tick(); step(1);
        flag_wr = 1'b1; flag_wr_data = 1'b0; tick_8us = 1'b1;
        step(1);
        flag_wr = 1'b0; tick_8us = 1'b0;
        chk("R6 set wins over clear", reset_flag, 1'b1);
        go_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule